// File: doc/BRIEF.md
# DRAM CBR Refresh and Self-Refresh Sequencer

This block owns the refresh side of an asynchronous DRAM's row and column strobes. In normal operation an interval counter raises a refresh request every `REF_INTERVAL` clock cycles. The sequencer then withdraws its grant from the access controller and waits until the controller reports that it is idle. It then drives a CAS-before-RAS cycle on the strobes. While the grant is held, the controller's strobes pass through to the memory unchanged.

When the system raises `sleep_req`, the sequencer runs an extended CAS-before-RAS cycle that puts the memory into self-refresh. CAS falls first and RAS follows. CAS is kept low for a minimum hold time and then released. RAS is kept low, and `sleep_ack` rises only once RAS has been low for the minimum self-refresh time. When `sleep_req` drops, RAS is raised, and `sleep_ack` stays high until RAS has been high for the minimum exit time. The sequencer then issues one CBR refresh at once and restarts the interval counter, so that every refresh after wake-up is a CBR refresh.

All times are parameters counted in clock cycles. Page-mode transfers, address multiplexing and power-up initialisation are handled elsewhere.

Top module: `dram_selfref_seq`

## Requirements
- R1: While `rst_n` is low and right after reset, `ctl_grant` is 1, `sleep_ack` is 0, and `ras_n`/`cas_n` equal `ctl_ras_n`/`ctl_cas_n`.
- R2: With the controller idle and no sleep request, the CAS falls of successive refresh cycles are exactly `REF_INTERVAL` cycles apart.
- R3: In every cycle the sequencer drives, CAS falls first and stays low, with RAS high, for exactly `CAS_LEAD` cycles before RAS falls.
- R4: A normal refresh holds RAS and CAS low together for `CBR_LOW` cycles and raises both in the same cycle. Both then stay high for `CBR_PRE` cycles, after which `ctl_grant` returns to 1.
- R5: While a refresh or sleep is pending, `ctl_grant` is 0 and the strobes follow the controller as long as `ctl_busy` is 1. In the cycle after `ctl_busy` is sampled at 0, `cas_n` is 0 and `ras_n` is 1.
- R6: On self-refresh entry, CAS stays low for `SR_CAS_HOLD` cycles after RAS falls and is then released while RAS stays low.
- R7: `sleep_ack` rises when RAS has been low for exactly `SR_RAS_MIN` cycles. While the memory is asleep, RAS stays low, CAS stays high, `ctl_grant` is 0 and no refresh is issued.
- R8: When `sleep_req` drops, RAS rises in the next cycle. `sleep_ack` stays 1 until RAS has been high for `SR_EXIT_MIN` cycles and falls in the cycle after that.
- R9: CAS falls for a resynchronising CBR refresh in the same cycle that `sleep_ack` falls. The next periodic refresh's CAS fall comes `REF_INTERVAL + 2` cycles later.
- R10: A sleep request that is present when a pending refresh wins the strobes is served by the self-refresh entry alone. RAS does not rise between the entry's RAS fall and the rise of `sleep_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | System asks for self-refresh (level) |
| ctl_busy | input | 1 | Access controller still has a cycle in progress |
| ctl_ras_n | input | 1 | Controller's row strobe |
| ctl_cas_n | input | 1 | Controller's column strobe |
| ctl_grant | output | 1 | Controller may start new accesses |
| sleep_ack | output | 1 | Memory is in self-refresh (exit time still running) |
| ras_n | output | 1 | Row strobe to the memory |
| cas_n | output | 1 | Column strobe to the memory |

## Verification
The bench measures strobe run lengths at the pins. A design with an off-by-one timer would show up as a CAS lead, RAS-low, hold or exit run that is one cycle short. Holding `ctl_busy` with the strobes toggling checks that a sequencer which does not wait would be caught taking the strobes from the controller. The wake-up path is checked for whether `sleep_ack` drops before the exit time has run. It is also checked for whether the resynchronising refresh is skipped and whether the interval counter keeps stale time instead of restarting. A refresh and a sleep request that compete for the same slot would show up as an extra RAS rise before the acknowledge.

// File: rtl/dram_selfref_seq.sv
module dram_selfref_seq #(
  parameter int REF_INTERVAL = 780,
  parameter int CAS_LEAD     = 2,
  parameter int CBR_LOW      = 4,
  parameter int CBR_PRE      = 3,
  parameter int SR_CAS_HOLD  = 4,
  parameter int SR_RAS_MIN   = 10,
  parameter int SR_EXIT_MIN  = 12,
  parameter int TIMER_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic ctl_busy,
  input  logic ctl_ras_n,
  input  logic ctl_cas_n,
  output logic ctl_grant,
  output logic sleep_ack,
  output logic ras_n,
  output logic cas_n
);
  localparam int RW = $clog2(REF_INTERVAL + 1);
  localparam logic [RW-1:0] REF_RELOAD = RW'(REF_INTERVAL - 1);
  localparam logic [TIMER_W-1:0] T_LEAD  = TIMER_W'(CAS_LEAD - 1);
  localparam logic [TIMER_W-1:0] T_CBR   = TIMER_W'(CBR_LOW - 1);
  localparam logic [TIMER_W-1:0] T_PRE   = TIMER_W'(CBR_PRE - 1);
  localparam logic [TIMER_W-1:0] T_SRCAS = TIMER_W'(SR_CAS_HOLD - 1);
  localparam logic [TIMER_W-1:0] T_SRRAS = TIMER_W'(SR_RAS_MIN - SR_CAS_HOLD - 1);
  localparam logic [TIMER_W-1:0] T_EXIT  = TIMER_W'(SR_EXIT_MIN - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_LEAD, S_CBR, S_PRE, S_SRCAS, S_SRRAS, S_SRHOLD, S_SREXIT
  } state_t;

  state_t             st;
  logic [TIMER_W-1:0] tmr;
  logic [RW-1:0]      ref_cnt;
  logic               pend, sr_mode;

  wire done     = (tmr == '0);
  wire in_sleep = st inside {S_SRCAS, S_SRRAS, S_SRHOLD, S_SREXIT};
  wire own      = !(st inside {S_IDLE, S_WAIT});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      ref_cnt <= REF_RELOAD;
      pend    <= 1'b0;
      sr_mode <= 1'b0;
    end else begin
      if (!in_sleep) begin
        if (ref_cnt == '0) begin
          ref_cnt <= REF_RELOAD;
          pend    <= 1'b1;
        end else begin
          ref_cnt <= ref_cnt - 1'b1;
        end
      end
      if (!done) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE:  if (pend || sleep_req) st <= S_WAIT;
        S_WAIT:  if (!ctl_busy) begin
                   st      <= S_LEAD;
                   tmr     <= T_LEAD;
                   sr_mode <= sleep_req;
                   pend    <= 1'b0;
                 end
        S_LEAD:  if (done) begin
                   st  <= sr_mode ? S_SRCAS : S_CBR;
                   tmr <= sr_mode ? T_SRCAS : T_CBR;
                 end
        S_CBR:   if (done) begin st <= S_PRE; tmr <= T_PRE; end
        S_PRE:   if (done) st <= S_IDLE;
        S_SRCAS: if (done) begin st <= S_SRRAS; tmr <= T_SRRAS; end
        S_SRRAS: if (done) st <= S_SRHOLD;
        S_SRHOLD: if (!sleep_req) begin st <= S_SREXIT; tmr <= T_EXIT; end
        S_SREXIT: if (done) begin
                   st      <= S_LEAD;
                   tmr     <= T_LEAD;
                   sr_mode <= 1'b0;
                   ref_cnt <= REF_RELOAD;
                   pend    <= 1'b0;
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctl_grant = (st == S_IDLE);
  assign sleep_ack = st inside {S_SRHOLD, S_SREXIT};
  assign ras_n = own ? !(st inside {S_CBR, S_SRCAS, S_SRRAS, S_SRHOLD}) : ctl_ras_n;
  assign cas_n = own ? !(st inside {S_LEAD, S_CBR, S_SRCAS}) : ctl_cas_n;

  logic [TIMER_W-1:0] ras_lo_cyc, ras_hi_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cyc <= '0;
      ras_hi_cyc <= '0;
    end else begin
      ras_lo_cyc <= ras_n ? '0 : ras_lo_cyc + TIMER_W'(ras_lo_cyc != '1);
      ras_hi_cyc <= !ras_n ? '0 : ras_hi_cyc + TIMER_W'(ras_hi_cyc != '1);
    end
  end

  // R3
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own && $fell(ras_n) |-> !cas_n && !$past(cas_n));

  // R4
  grant_after_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_grant) |-> $past(ras_n) && $past(cas_n));

  // R5
  take_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own && !$past(own) |-> !$past(ctl_busy));

  // R7
  ack_after_ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> ras_lo_cyc >= TIMER_W'(SR_RAS_MIN));

  // R8
  wake_after_exit_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> ras_hi_cyc >= TIMER_W'(SR_EXIT_MIN));
endmodule

// File: tb/test_dram_selfref_seq.sv
module test_dram_selfref_seq;
  localparam int RI = 40, LEAD = 2, CLOW = 3, CPRE = 2, SRCH = 3, SRMIN = 6, SREXIT = 4;

  logic clk = 0, rst_n = 0, sleep_req = 0, ctl_busy = 0, ctl_ras_n = 1, ctl_cas_n = 1;
  logic ctl_grant, sleep_ack, ras_n, cas_n;

  dram_selfref_seq #(.REF_INTERVAL(RI), .CAS_LEAD(LEAD), .CBR_LOW(CLOW), .CBR_PRE(CPRE),
    .SR_CAS_HOLD(SRCH), .SR_RAS_MIN(SRMIN), .SR_EXIT_MIN(SREXIT), .TIMER_W(8)) i_dram_selfref_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ctl_busy(ctl_busy),
    .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n), .ctl_grant(ctl_grant),
    .sleep_ack(sleep_ack), .ras_n(ras_n), .cas_n(cas_n));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic p_ras = 1, p_cas = 1, ras_fell, ras_rose, cas_fell, cas_rose;
  int ras_run = 0, cas_run = 0, last_ras_run = 0, lead_at_fall = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    ras_fell = p_ras && !ras_n; ras_rose = !p_ras && ras_n;
    cas_fell = p_cas && !cas_n; cas_rose = !p_cas && cas_n;
    if (ras_n != p_ras) begin last_ras_run = ras_run; ras_run = 1; end else ras_run++;
    if (cas_n != p_cas) cas_run = 1; else cas_run++;
    if (ras_fell) lead_at_fall = cas_n ? 0 : cas_run - 1;
    p_ras = ras_n; p_cas = cas_n;
  endtask

  task automatic finish_cbr();
    int n = 0;
    do begin step(); n++; end while (!ras_fell && n < 50);
    chk(ras_fell, "R3 ras fall", n, LEAD);
    chk(lead_at_fall == LEAD, "R3 cas lead", lead_at_fall, LEAD);
    n = 0;
    do begin step(); n++; end while (!ras_rose && n < 50);
    chk(last_ras_run == CLOW, "R4 ras low", last_ras_run, CLOW);
    chk(cas_n == 1 && cas_rose, "R4 cas rises with ras", cas_n, 1);
    n = 0;
    while (!ctl_grant && n < 50) begin step(); n++; end
    chk(n == CPRE, "R4 precharge before grant", n, CPRE);
  endtask

  task automatic observe_cbr(output int fall_cyc);
    int n = 0;
    do begin step(); n++; end while (!cas_fell && n < 200);
    chk(cas_fell, "R2 refresh seen", n, RI);
    fall_cyc = cyc;
    finish_cbr();
  endtask

  initial begin
    int f1, f2, f3, n, bad, rises, resync;
    ctl_ras_n = 0;
    repeat (3) step();
    chk(ras_n == 0 && cas_n == 1, "R1 passthrough in reset", {ras_n, cas_n}, 1);
    chk(ctl_grant == 1, "R1 grant", ctl_grant, 1);
    chk(sleep_ack == 0, "R1 ack", sleep_ack, 0);
    ctl_ras_n = 1;
    step();
    rst_n = 1;
    step();
    chk(ras_n == 1 && cas_n == 1 && ctl_grant == 1 && sleep_ack == 0, "R1 after reset",
        {ras_n, cas_n, ctl_grant, sleep_ack}, 4'b1110);

    observe_cbr(f1);
    observe_cbr(f2);
    observe_cbr(f3);
    chk(f2 - f1 == RI, "R2 interval", f2 - f1, RI);
    chk(f3 - f2 == RI, "R2 interval", f3 - f2, RI);

    ctl_busy = 1;
    n = 0;
    while (ctl_grant && n < 100) begin step(); n++; end
    chk(!ctl_grant, "R5 grant withdrawn", ctl_grant, 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      ctl_ras_n = i[0]; ctl_cas_n = i[1];
      step();
      if (ras_n != ctl_ras_n || cas_n != ctl_cas_n || ctl_grant) bad++;
    end
    chk(bad == 0, "R5 strobes follow busy controller", bad, 0);
    ctl_ras_n = 1; ctl_cas_n = 1; ctl_busy = 0;
    step();
    chk(cas_n == 0 && ras_n == 1, "R5 take after idle", {ras_n, cas_n}, 2);
    finish_cbr();

    sleep_req = 1;
    n = 0;
    do begin step(); n++; end while (!cas_fell && n < 20);
    chk(cas_fell && ras_n, "R3 sleep cas first", ras_n, 1);
    do begin step(); n++; end while (!ras_fell && n < 40);
    chk(lead_at_fall == LEAD, "R3 sleep cas lead", lead_at_fall, LEAD);
    do begin step(); n++; end while (!cas_rose && n < 60);
    chk(ras_n == 0 && ras_run - 1 == SRCH, "R6 cas hold", ras_run - 1, SRCH);
    do begin step(); n++; end while (!sleep_ack && n < 80);
    chk(ras_n == 0 && ras_run - 1 == SRMIN, "R7 ack after ras min", ras_run - 1, SRMIN);
    chk(!ctl_grant, "R7 no grant asleep", ctl_grant, 0);
    bad = 0;
    for (int i = 0; i < 3 * RI; i++) begin
      step();
      if (ras_n || !cas_n || !sleep_ack || ctl_grant) bad++;
    end
    chk(bad == 0, "R7 hold with no refresh", bad, 0);
    sleep_req = 0;
    step();
    chk(ras_n == 1 && sleep_ack == 1, "R8 ras rises ack held", {ras_n, sleep_ack}, 3);
    n = 0;
    while (sleep_ack && n < 50) begin step(); n++; end
    chk(ras_n == 1 && ras_run - 1 == SREXIT, "R8 exit time", ras_run - 1, SREXIT);
    chk(cas_fell, "R9 resync cas with wake", cas_n, 0);
    resync = cyc;
    finish_cbr();
    observe_cbr(f1);
    chk(f1 - resync == RI + 2, "R9 counter restarted", f1 - resync, RI + 2);

    ctl_busy = 1;
    n = 0;
    while (ctl_grant && n < 100) begin step(); n++; end
    chk(!ctl_grant, "R10 refresh pending", ctl_grant, 0);
    sleep_req = 1; ctl_busy = 0;
    step();
    chk(cas_n == 0 && ras_n == 1, "R5 take for sleep", {ras_n, cas_n}, 2);
    rises = 0; n = 0;
    do begin step(); n++; if (ras_rose) rises++; end while (!sleep_ack && n < 80);
    chk(rises == 0, "R10 no extra refresh", rises, 0);
    chk(ras_run - 1 == SRMIN, "R10 R7 ack timing", ras_run - 1, SRMIN);
    sleep_req = 0;
    n = 0;
    while (sleep_ack && n < 50) begin step(); n++; end
    chk(ras_run - 1 == SREXIT && cas_fell, "R8 R9 second wake", ras_run - 1, SREXIT);
    finish_cbr();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule